// File: doc/BRIEF.md
# SPI Memory Slave Command Front-End

This block is the serial front end of a memory that hangs on an SPI bus as a slave. It watches chip select, serial clock, serial data in and a hold pin. All four are brought into the system clock domain and edge-detected there. The first complete byte after select is taken as the command. The bytes that follow go to the memory core one at a time as single-cycle pulses. Bytes that the core wants to send back are shifted out on the serial data output, with a separate output-enable for the pad. Only the two clock polarities whose sampling edge is the rising edge are used: idle low (mode 0) and idle high (mode 3).

The controller has four named states. `ST_IDLE` means deselected. `ST_OPC` means the command byte is being collected. `ST_DATA` means a known command was accepted and bytes are flowing. `ST_LOCK` means an unknown command was seen and the interface is silent.
- `ST_IDLE -> ST_OPC` when select goes low.
- `ST_OPC -> ST_DATA` when the eighth bit completes a known command.
- `ST_OPC -> ST_LOCK` when the eighth bit completes an unknown command.
- Every state returns to `ST_IDLE` when select goes high.

A pause flag runs beside the state machine. It may change only while the serial clock is low. While it is set, clock edges are dropped, so the transfer resumes exactly where it stopped.

Top module: `spi_slave_front`

## Requirements
- R1: In both modes, serial data is sampled on rising SCK edges and assembled most significant bit first. A byte is complete after eight accepted rising edges.
- R2: The first byte after select is the command. Known commands are 0x06, 0x04, 0x05, 0x01, 0x03, 0x02 and 0x52. A known command gives a one-cycle `cmd_valid` pulse and is held on `cmd_code` until select rises.
- R3: Each later byte of an accepted command gives a one-cycle `rx_valid` pulse with the byte on `rx_byte`. `cmd_valid` and `rx_valid` never pulse together.
- R4: After an unknown command, no further byte is reported and `so_oe` stays low until select goes high and low again. The next select then decodes a new command normally.
- R5: While select is high, serial data is ignored and `so_oe` is low. Select rising at any point drops a partial byte and clears `cmd_code` to 0x00.
- R6: After each byte boundary of an accepted command, `tx_byte` and `tx_en` are captured at the next falling SCK edge. The byte is driven MSB first on `so`, changing only on falling edges, and `so_oe` follows the captured `tx_en`.
- R7: The pause begins only while SCK is low. If the hold pin drops while SCK is high, nothing changes until SCK falls.
- R8: While paused, SCK edges and serial data are ignored, `so_oe` is low, and the bit position does not advance. After release the byte continues from the same bit.
- R9: The pause ends only while SCK is low. If the hold pin is released while SCK is high, the block stays paused until SCK is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than 4x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for `so` (low = high impedance) |
| cmd_valid | output | 1 | One-cycle pulse: known command accepted |
| cmd_code | output | 8 | Accepted command, 0x00 while deselected |
| rx_valid | output | 1 | One-cycle pulse: data byte received |
| rx_byte | output | 8 | Last data byte received |
| tx_byte | input | 8 | Byte the core wants to send next |
| tx_en | input | 1 | Drive the next byte onto the pin |

## Verification
On every cycle the assertions check the following:
- the output is off after a deselect and in the locked state;
- the pause flag enters and leaves only with SCK low;
- the bit position stays frozen while paused;
- a reported command is always a known code and arrives only with the transition into `ST_DATA`;
- the two byte pulses are exclusive.

Only the bench scenarios can show the rest: the values that come out, meaning bytes assembled correctly in both clock modes, the returned byte arriving bit for bit in MSB order, a paused byte resuming at the right bit, an aborted partial byte leaving no trace, and recovery after the lock.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPC,
        ST_DATA,
        ST_LOCK
    } fe_state_t;

    localparam logic [BYTE_W-1:0] CMD_WR_ENA   = 8'h06;
    localparam logic [BYTE_W-1:0] CMD_WR_DIS   = 8'h04;
    localparam logic [BYTE_W-1:0] CMD_STAT_RD  = 8'h05;
    localparam logic [BYTE_W-1:0] CMD_STAT_WR  = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_ARR_RD   = 8'h03;
    localparam logic [BYTE_W-1:0] CMD_ARR_PROG = 8'h02;
    localparam logic [BYTE_W-1:0] CMD_SECT_ERS = 8'h52;

    function automatic logic fe_known_cmd(input logic [BYTE_W-1:0] b);
        case (b)
            CMD_WR_ENA, CMD_WR_DIS, CMD_STAT_RD, CMD_STAT_WR,
            CMD_ARR_RD, CMD_ARR_PROG, CMD_SECT_ERS: return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
// Multi-stage synchronizer bank for the serial pins.
module spi_fe_sync #(
    parameter int          N_SIG   = 4,
    parameter int          STAGES  = 2,
    parameter logic [N_SIG-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] din,
    output logic [N_SIG-1:0] dout
);

    for (genvar g = 0; g < N_SIG; g++) begin : g_chain
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[g]}};
            end else begin
                chain <= {chain[STAGES-2:0], din[g]};
            end
        end
        assign dout[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_fe_pace.sv
// Pause flag and qualified SCK edges.
module spi_fe_pace (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_hi,
    input  logic sck_lvl,
    input  logic hold_lvl,
    output logic held,
    output logic rise_ok,
    output logic fall_ok
);

    logic sck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            held     <= 1'b0;
        end else begin
            sck_prev <= sck_lvl;
            if (cs_hi) begin
                held <= 1'b0;
            end else if (!sck_lvl) begin
                held <= ~hold_lvl;
            end
        end
    end

    assign rise_ok = sck_lvl & ~sck_prev & ~held & ~cs_hi;
    assign fall_ok = ~sck_lvl & sck_prev & ~held & ~cs_hi;

endmodule

// File: rtl/spi_fe_tx.sv
// Falling-edge output shifter with deferred byte capture.
module spi_fe_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load_req,
    input  logic              fall_ok,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_en,
    output logic              so,
    output logic              drive
);

    logic [BYTE_W-1:0] out_sr;
    logic              pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_sr <= '0;
            pend   <= 1'b0;
            drive  <= 1'b0;
        end else if (clear) begin
            out_sr <= '0;
            pend   <= 1'b0;
            drive  <= 1'b0;
        end else begin
            if (load_req) begin
                pend <= 1'b1;
            end
            if (fall_ok) begin
                if (pend) begin
                    out_sr <= tx_byte;
                    drive  <= tx_en;
                    pend   <= 1'b0;
                end else begin
                    out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign so = out_sr[BYTE_W-1];

endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front
    import spi_fe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_code,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_en
);

    localparam int N_PINS = 4;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [N_PINS-1:0] pins_raw, pins_s;
    logic cs_hi, sck_lvl, si_lvl, hold_lvl;
    logic held, rise_ok, fall_ok, drive;

    fe_state_t         state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] in_sr;
    logic [BYTE_W-1:0] byte_now;
    logic              shift_en, byte_done, cmd_ok, load_req, tx_clear;

    assign pins_raw = {hold_n, si, sck, cs_n};

    spi_fe_sync #(
        .N_SIG   (N_PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    assign cs_hi    = pins_s[0];
    assign sck_lvl  = pins_s[1];
    assign si_lvl   = pins_s[2];
    assign hold_lvl = pins_s[3];

    spi_fe_pace u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_hi   (cs_hi),
        .sck_lvl (sck_lvl),
        .hold_lvl(hold_lvl),
        .held    (held),
        .rise_ok (rise_ok),
        .fall_ok (fall_ok)
    );

    assign shift_en  = rise_ok & ((state_q == ST_OPC) | (state_q == ST_DATA));
    assign byte_done = shift_en & (bit_cnt == LAST_BIT);
    assign byte_now  = {in_sr[BYTE_W-2:0], si_lvl};
    assign cmd_ok    = fe_known_cmd(byte_now);
    assign load_req  = byte_done & ((state_q == ST_DATA) | ((state_q == ST_OPC) & cmd_ok));
    assign tx_clear  = cs_hi | (state_q == ST_IDLE) | (state_q == ST_LOCK);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!cs_hi) state_d = ST_OPC;
            ST_OPC: begin
                if (cs_hi)          state_d = ST_IDLE;
                else if (byte_done) state_d = cmd_ok ? ST_DATA : ST_LOCK;
            end
            ST_DATA: if (cs_hi) state_d = ST_IDLE;
            ST_LOCK: if (cs_hi) state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit position and input shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            in_sr   <= '0;
        end else if (cs_hi || state_q == ST_IDLE) begin
            bit_cnt <= '0;
            in_sr   <= '0;
        end else if (shift_en) begin
            bit_cnt <= bit_cnt + 1'b1;
            in_sr   <= byte_now;
        end
    end

    // Registered outputs toward the core
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_code  <= '0;
            rx_valid  <= 1'b0;
            rx_byte   <= '0;
        end else begin
            cmd_valid <= 1'b0;
            rx_valid  <= 1'b0;
            if (cs_hi) begin
                cmd_code <= '0;
            end else if (byte_done) begin
                if (state_q == ST_OPC && cmd_ok) begin
                    cmd_valid <= 1'b1;
                    cmd_code  <= byte_now;
                end else if (state_q == ST_DATA) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= byte_now;
                end
            end
        end
    end

    spi_fe_tx #(
        .BYTE_W(BYTE_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tx_clear),
        .load_req(load_req),
        .fall_ok (fall_ok),
        .tx_byte (tx_byte),
        .tx_en   (tx_en),
        .so      (so),
        .drive   (drive)
    );

    assign so_oe = drive & ~held;

endmodule

// File: rtl/spi_slave_front_chk.sv
module spi_slave_front_chk
    import spi_fe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_hi,
    input logic              held,
    input logic              sck_lvl,
    input fe_state_t         state_q,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              so_oe,
    input logic              cmd_valid,
    input logic [BYTE_W-1:0] cmd_code,
    input logic              rx_valid
);

    a_r5_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !so_oe);

    a_r4_lock_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK) |-> (!so_oe && !rx_valid && !cmd_valid));

    a_r7_pause_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(!sck_lvl));

    a_r9_pause_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(held) && !$past(cs_hi)) |-> $past(!sck_lvl));

    a_r8_pause_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !cs_hi) |=> $stable(bit_cnt));

    a_r2_known_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (fe_known_cmd(cmd_code) && state_q == ST_DATA));

    a_r3_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, rx_valid}));

endmodule

bind spi_slave_front spi_slave_front_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_hi    (cs_hi),
    .held     (held),
    .sck_lvl  (sck_lvl),
    .state_q  (state_q),
    .bit_cnt  (bit_cnt),
    .so_oe    (so_oe),
    .cmd_valid(cmd_valid),
    .cmd_code (cmd_code),
    .rx_valid (rx_valid)
);

// File: tb/spi_slave_front_test.sv
module spi_slave_front_test;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       hold_n = 1'b1;
    logic       so, so_oe, cmd_valid, rx_valid, tx_en = 1'b0;
    logic [7:0] cmd_code, rx_byte, tx_byte = 8'h00;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int cmd_cnt = 0;
    int rx_cnt  = 0;
    logic [7:0] rx_log [4];

    always #4 clk = ~clk;

    spi_slave_front uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .so(so), .so_oe(so_oe), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx_byte), .tx_en(tx_en)
    );

    always @(negedge clk) begin
        if (cmd_valid) cmd_cnt++;
        if (rx_valid) begin
            rx_log[rx_cnt % 4] = rx_byte;
            rx_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic idle_mode(input bit m3);
        sck = m3;
        half();
    endtask

    task automatic select();
        cs_n = 1'b0;
        half();
    endtask

    task automatic deselect(input bit m3);
        if (!m3) sck = 1'b0;
        half();
        cs_n = 1'b1;
        half();
        half();
    endtask

    task automatic pause_window();
        hold_n = 1'b0;
        half();
        check("R7", so_oe, 1, "output still on, hold low with SCK high");
        sck = 1'b0;
        half();
        check("R8", so_oe, 0, "output off once paused");
        for (int k = 0; k < 3; k++) begin
            si = ~si; sck = 1'b1; half();
            sck = 1'b0; half();
        end
        sck = 1'b1;
        half();
        hold_n = 1'b1;
        half();
        check("R9", so_oe, 0, "still paused, release with SCK high");
        sck = 1'b0;
        half();
        check("R9", so_oe, 1, "resumed after SCK low");
    endtask

    task automatic xfer(input logic [7:0] mosi, input int nbits, input int pause_at,
                        output logic [7:0] miso, output int oe_hits);
        miso = 8'h00;
        oe_hits = 0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            sck = 1'b0;
            si = mosi[i];
            half();
            miso[i] = so;
            if (so_oe) oe_hits++;
            sck = 1'b1;
            half();
            if (i == pause_at) pause_window();
        end
    endtask

    task automatic t_reset();
        check("R5", so_oe, 0, "reset output enable");
        check("R5", cmd_code, 0, "reset command");
        check("R2", cmd_cnt, 0, "no command at reset");
    endtask

    task automatic t_mode0_program();
        logic [7:0] m;
        int oe, base_rx;
        base_rx = rx_cnt;
        tx_en = 1'b0;
        idle_mode(1'b0);
        select();
        xfer(8'h02, 8, -1, m, oe);
        half();
        check("R2", cmd_code, 8'h02, "program command held");
        check("R2", cmd_cnt, 1, "one command pulse");
        xfer(8'h3C, 8, -1, m, oe);
        xfer(8'hC3, 8, -1, m, oe);
        half();
        check("R3", rx_cnt - base_rx, 2, "data byte pulses");
        check("R1", rx_log[base_rx % 4], 8'h3C, "mode 0 first data byte");
        check("R1", rx_log[(base_rx + 1) % 4], 8'hC3, "mode 0 second data byte");
        check("R6", oe, 0, "no drive with tx_en low");
        deselect(1'b0);
        check("R5", cmd_code, 0, "command cleared on deselect");
    endtask

    task automatic t_mode3_status();
        logic [7:0] m;
        int oe;
        tx_en = 1'b1;
        tx_byte = 8'hA5;
        idle_mode(1'b1);
        select();
        xfer(8'h05, 8, -1, m, oe);
        check("R6", oe, 0, "no drive during command byte");
        xfer(8'h00, 8, -1, m, oe);
        check("R6", m, 8'hA5, "mode 3 returned byte");
        check("R6", oe, 8, "drive on for all eight bits");
        check("R2", cmd_code, 8'h05, "status read command");
        deselect(1'b1);
        check("R5", so_oe, 0, "output off after deselect");
    endtask

    task automatic t_invalid();
        logic [7:0] m;
        int oe, c0, r0;
        c0 = cmd_cnt;
        r0 = rx_cnt;
        tx_en = 1'b1;
        tx_byte = 8'hFF;
        idle_mode(1'b0);
        select();
        xfer(8'hFF, 8, -1, m, oe);
        xfer(8'h55, 8, -1, m, oe);
        check("R4", cmd_cnt - c0, 0, "unknown command not reported");
        check("R4", rx_cnt - r0, 0, "locked bytes not reported");
        check("R4", oe, 0, "output stays off while locked");
        deselect(1'b0);
        select();
        xfer(8'h06, 8, -1, m, oe);
        half();
        check("R4", cmd_cnt - c0, 1, "recovery after reselect");
        check("R4", cmd_code, 8'h06, "recovered command value");
        deselect(1'b0);
    endtask

    task automatic t_abort();
        logic [7:0] m;
        int oe;
        tx_en = 1'b0;
        idle_mode(1'b0);
        select();
        xfer(8'hA0, 4, -1, m, oe);
        deselect(1'b0);
        check("R5", cmd_code, 0, "partial byte left no command");
        select();
        xfer(8'h04, 8, -1, m, oe);
        half();
        check("R5", cmd_code, 8'h04, "fresh command after abort");
        deselect(1'b0);
    endtask

    task automatic t_pause();
        logic [7:0] m;
        int oe, r0;
        r0 = rx_cnt;
        tx_en = 1'b1;
        tx_byte = 8'h96;
        idle_mode(1'b0);
        select();
        xfer(8'h03, 8, -1, m, oe);
        xfer(8'h5A, 8, 4, m, oe);
        half();
        check("R8", m, 8'h96, "returned byte intact across pause");
        check("R8", rx_cnt - r0, 1, "one byte across pause");
        check("R8", rx_log[r0 % 4], 8'h5A, "received byte intact across pause");
        deselect(1'b0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_mode0_program();
        t_mode3_status();
        t_invalid();
        t_abort();
        t_pause();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule